// File: doc/BRIEF.md
# Cartridge work-RAM enable generator

This block produces the chip enables and the write strobe for the battery-backed work RAM of a bank-switching cartridge controller. The host CPU runs cycles framed by its M2 phase clock. The block watches M2, R/W, the ROM-select line and address bits A0, A13 and A14. A CPU cycle to the $6000-$7FFF window reaches the RAM only if a two-bit protect register allows it. The block also produces a delayed copy of M2 for other parts of the cartridge.

The nanosecond delays are measured in edges of a fast reference clock, 50 MHz by default. Each delay is a parameter. The enables turn on a set number of reference edges after M2 goes high and turn off a set number of edges after M2 goes low. The write strobe and the delayed M2 each have their own delay pair. The write strobe follows any CPU write cycle and does not depend on the protect register.

Top module: `wram_ctrl`

## Requirements
- R1: After reset, and whenever no cycle is in progress, `ram_ce` is 0, `ram_ce_n` is 1, `ram_we_n` is 1 and `m2_dly` is 0.
- R2: A read cycle in the window (`romsel_n`=1, `cpu_a14`=1, `cpu_a13`=1) asserts both enables only when protect bit 1 (written from D7) is 1. The enables assert at the CE_ON_CYC-th reference edge at which M2 is sampled high.
- R3: A write cycle in the window asserts both enables only when protect bit 1 is 1 and protect bit 0 (written from D6) is 0, with the same timing as R2.
- R4: Once asserted, the enables stay on until the CE_OFF_CYC-th reference edge at which M2 is sampled low. `ram_ce_n` is always the complement of `ram_ce`.
- R5: `ram_we_n` goes low at the WE_ON_CYC-th reference edge at which M2 is sampled high during any cycle with `cpu_rw`=0. This holds for any address and any protect value. It returns high at the WE_OFF_CYC-th edge with M2 low.
- R6: `m2_dly` rises at the M2D_ON_CYC-th edge with M2 high and falls at the M2D_OFF_CYC-th edge with M2 low.
- R7: If M2 falls before an assert delay has run out, that output does not assert for that cycle.
- R8: The protect register takes `cpu_d_hi` (bit 1 = D7, bit 0 = D6) from a write cycle with `romsel_n`=0, `cpu_a14`=0, `cpu_a13`=1 and `cpu_a0`=1. The new value is committed at the first reference edge after M2 falls. A write with `cpu_a0`=0 leaves the register unchanged.
- R9: A cycle outside the window (`romsel_n`=0, or `cpu_a13` or `cpu_a14` at 0) never asserts the enables.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock used to count the delays |
| rst_n | input | 1 | Active-low reset |
| m2 | input | 1 | CPU phase clock, high during the data phase |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| romsel_n | input | 1 | Active-low ROM select from the host |
| cpu_a0 | input | 1 | CPU address bit 0 |
| cpu_a13 | input | 1 | CPU address bit 13 |
| cpu_a14 | input | 1 | CPU address bit 14 |
| cpu_d_hi | input | 2 | CPU data bits D7 (bit 1) and D6 (bit 0) |
| ram_ce | output | 1 | Active-high RAM enable |
| ram_ce_n | output | 1 | Active-low RAM enable |
| ram_we_n | output | 1 | Active-low RAM write strobe |
| m2_dly | output | 1 | Delayed copy of M2 |

## Verification
The assertions assume that address, R/W and data stay stable while M2 is high. They also assume that each M2 low phase lasts at least as many reference edges as the longest release delay, so an enable can only turn off after M2 falls. The stimulus changes the bus only at the start of a cycle, while M2 is low. Every low phase lasts at least five reference cycles, and every high phase lasts two to fourteen cycles, so some are shorter than the assert delays. The bench writes the protect register before it checks any enable, so no power-up value is assumed.

// File: rtl/wram_pkg.sv
package wram_pkg;

    // One snapshot of the host bus while M2 is high
    typedef struct packed {
        logic       rw;
        logic       romsel_n;
        logic       a0;
        logic       a13;
        logic       a14;
        logic [1:0] d;
    } bus_s;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/wram_phase_timer.sv
// Counts reference edges spent in the current M2 phase (high or low).
module wram_phase_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          m2,
    output logic [CW-1:0] hi_cnt,
    output logic [CW-1:0] lo_cnt
);
    localparam logic [CW-1:0] SAT = '1;

    typedef struct packed {
        logic [CW-1:0] hi;
        logic [CW-1:0] lo;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (m2) begin
            st_d.lo = '0;
            if (st_q.hi != SAT) st_d.hi = st_q.hi + 1'b1;
        end else begin
            st_d.hi = '0;
            if (st_q.lo != SAT) st_d.lo = st_q.lo + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hi_cnt = st_q.hi;
    assign lo_cnt = st_q.lo;
endmodule

// File: rtl/wram_delay_line.sv
// One output that asserts ON edges into the M2 high phase (if requested)
// and releases OFF edges into the M2 low phase.
module wram_delay_line #(
    parameter int CW  = 4,
    parameter int ON  = 6,
    parameter int OFF = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          m2,
    input  logic          req,
    input  logic [CW-1:0] hi_cnt,
    input  logic [CW-1:0] lo_cnt,
    output logic          act
);
    localparam logic [CW-1:0] ON_M1  = CW'(ON - 1);
    localparam logic [CW-1:0] OFF_M1 = CW'(OFF - 1);

    typedef struct packed {
        logic act;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (m2) st_d.act = req && (hi_cnt >= ON_M1);
        else    st_d.act = st_q.act && (lo_cnt < OFF_M1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign act = st_q.act;
endmodule

// File: rtl/wram_protect_reg.sv
// Two-bit RAM protect register, committed when M2 falls.
module wram_protect_reg
    import wram_pkg::*;
#(
    parameter logic [1:0] RST_VAL = 2'b00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       m2,
    input  bus_s       bus,
    output logic [1:0] prot
);
    typedef struct packed {
        logic       m2;
        bus_s       bus;
        logic [1:0] prot;
    } st_t;

    st_t  st_d, st_q;
    logic hit;

    always_comb begin
        st_d    = st_q;
        st_d.m2 = m2;
        if (m2) st_d.bus = bus;
        hit = !st_q.bus.rw && !st_q.bus.romsel_n && !st_q.bus.a14
              && st_q.bus.a13 && st_q.bus.a0;
        if (st_q.m2 && !m2 && hit) st_d.prot = st_q.bus.d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.prot <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign prot = st_q.prot;
endmodule

// File: rtl/wram_ctrl.sv
module wram_ctrl
    import wram_pkg::*;
#(
    parameter int         CE_ON_CYC   = 6,
    parameter int         CE_OFF_CYC  = 1,
    parameter int         WE_ON_CYC   = 9,
    parameter int         WE_OFF_CYC  = 1,
    parameter int         M2D_ON_CYC  = 5,
    parameter int         M2D_OFF_CYC = 4,
    parameter logic [1:0] PROT_RST    = 2'b00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       m2,
    input  logic       cpu_rw,
    input  logic       romsel_n,
    input  logic       cpu_a0,
    input  logic       cpu_a13,
    input  logic       cpu_a14,
    input  logic [1:0] cpu_d_hi,
    output logic       ram_ce,
    output logic       ram_ce_n,
    output logic       ram_we_n,
    output logic       m2_dly
);
    localparam int MAXD = max2(max2(max2(CE_ON_CYC, CE_OFF_CYC), max2(WE_ON_CYC, WE_OFF_CYC)),
                               max2(M2D_ON_CYC, M2D_OFF_CYC));
    localparam int CW   = $clog2(MAXD + 1);
    localparam int NOUT = 3;
    localparam int ON_T  [NOUT] = '{CE_ON_CYC, WE_ON_CYC, M2D_ON_CYC};
    localparam int OFF_T [NOUT] = '{CE_OFF_CYC, WE_OFF_CYC, M2D_OFF_CYC};

    logic [CW-1:0]   hi_cnt, lo_cnt;
    logic [1:0]      prot;
    logic [NOUT-1:0] req, act;
    logic            win, allow;
    bus_s            bus;

    always_comb begin
        bus     = '{rw: cpu_rw, romsel_n: romsel_n, a0: cpu_a0,
                    a13: cpu_a13, a14: cpu_a14, d: cpu_d_hi};
        win     = romsel_n && cpu_a14 && cpu_a13;
        allow   = prot[1] && (cpu_rw || !prot[0]);
        req[0]  = win && allow;
        req[1]  = !cpu_rw;
        req[2]  = 1'b1;
    end

    wram_phase_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .m2(m2), .hi_cnt(hi_cnt), .lo_cnt(lo_cnt)
    );

    wram_protect_reg #(.RST_VAL(PROT_RST)) u_prot (
        .clk(clk), .rst_n(rst_n), .m2(m2), .bus(bus), .prot(prot)
    );

    for (genvar i = 0; i < NOUT; i++) begin : g_dly
        wram_delay_line #(.CW(CW), .ON(ON_T[i]), .OFF(OFF_T[i])) u_dly (
            .clk(clk), .rst_n(rst_n), .m2(m2), .req(req[i]),
            .hi_cnt(hi_cnt), .lo_cnt(lo_cnt), .act(act[i])
        );
    end

    assign ram_ce   = act[0];
    assign ram_ce_n = !act[0];
    assign ram_we_n = !act[1];
    assign m2_dly   = act[2];
endmodule

// File: rtl/wram_ctrl_chk.sv
module wram_ctrl_chk #(
    parameter int CE_ON = 6
) (
    input logic clk,
    input logic rst_n,
    input logic m2,
    input logic cpu_rw,
    input logic ram_ce,
    input logic ram_we_n,
    input logic m2_dly
);
    int hseen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           hseen <= 0;
        else if (!m2)         hseen <= 0;
        else if (hseen < 1000) hseen <= hseen + 1;
    end

    // R2: enables only turn on during an M2 high phase
    a_r2_ce_rises_in_high: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_ce) |-> $past(m2));

    // R7: enables never turn on before the assert delay has elapsed
    a_r7_ce_not_early: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_ce) |-> ($past(hseen) >= CE_ON - 1));

    // R4: enables only turn off after M2 has fallen
    a_r4_ce_falls_in_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ram_ce) |-> !$past(m2));

    // R5: write strobe only goes low in a write cycle while M2 is high
    a_r5_we_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ram_we_n) |-> $past(m2 && !cpu_rw));

    // R6: delayed M2 follows the direction of M2
    a_r6_m2d_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(m2_dly) |-> $past(m2));
    a_r6_m2d_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(m2_dly) |-> !$past(m2));
endmodule

bind wram_ctrl wram_ctrl_chk #(.CE_ON(CE_ON_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .m2(m2), .cpu_rw(cpu_rw),
    .ram_ce(ram_ce), .ram_we_n(ram_we_n), .m2_dly(m2_dly)
);

// File: tb/tb_wram_ctrl.sv
module tb_wram_ctrl;
    localparam int PERIOD  = 20;
    localparam int CE_ON   = 6;
    localparam int CE_OFF  = 1;
    localparam int WE_ON   = 9;
    localparam int WE_OFF  = 1;
    localparam int MD_ON   = 5;
    localparam int MD_OFF  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m2 = 1'b0, cpu_rw = 1'b1, romsel_n = 1'b1;
    logic cpu_a0 = 1'b0, cpu_a13 = 1'b0, cpu_a14 = 1'b0;
    logic [1:0] cpu_d_hi = 2'b00;
    logic ram_ce, ram_ce_n, ram_we_n, m2_dly;

    int errors = 0;
    int checks = 0;

    // bench model state
    int   hk = 0, lk = 0;
    logic ce_m = 0, we_m = 0, md_m = 0;
    logic [1:0] prot_m = 2'b00;
    bit   prot_known = 0;
    logic last_reg_wr = 0;

    always #(PERIOD/2) clk = ~clk;

    wram_ctrl dut (
        .clk(clk), .rst_n(rst_n), .m2(m2), .cpu_rw(cpu_rw), .romsel_n(romsel_n),
        .cpu_a0(cpu_a0), .cpu_a13(cpu_a13), .cpu_a14(cpu_a14), .cpu_d_hi(cpu_d_hi),
        .ram_ce(ram_ce), .ram_ce_n(ram_ce_n), .ram_we_n(ram_we_n), .m2_dly(m2_dly)
    );

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: run did not complete (actual=hung expected=done)");
        finish_run();
    end

    task automatic chk(input string tag, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic bit in_window(input logic rs, input logic a14, input logic a13);
        return rs && a14 && a13;
    endfunction

    function automatic bit allowed(input logic [1:0] p, input logic rw);
        return p[1] && (rw || !p[0]);
    endfunction

    // advance the model by one reference edge
    task automatic model_step();
        if (m2) begin
            ce_m = in_window(romsel_n, cpu_a14, cpu_a13) && allowed(prot_m, cpu_rw)
                   && (hk >= CE_ON - 1);
            we_m = !cpu_rw && (hk >= WE_ON - 1);
            md_m = (hk >= MD_ON - 1);
            last_reg_wr = !cpu_rw && !romsel_n && !cpu_a14 && cpu_a13 && cpu_a0;
            hk++;
            lk = 0;
        end else begin
            ce_m = ce_m && (lk < CE_OFF - 1);
            we_m = we_m && (lk < WE_OFF - 1);
            md_m = md_m && (lk < MD_OFF - 1);
            if (hk > 0 && last_reg_wr) begin
                prot_m = cpu_d_hi_last;
                prot_known = 1;
            end
            hk = 0;
            lk++;
        end
    endtask

    logic [1:0] cpu_d_hi_last = 2'b00;
    always @(posedge clk) if (m2) cpu_d_hi_last <= cpu_d_hi;

    task automatic step_and_check(input string tag);
        @(posedge clk);
        #1;
        model_step();
        @(negedge clk);
        if (prot_known) begin
            chk(m2 ? tag : "R4", ram_ce, ce_m, "ram_ce");
            chk("R4", ram_ce_n, !ce_m, "ram_ce_n");
        end
        chk("R5", ram_we_n, !we_m, "ram_we_n");
        chk("R6", m2_dly, md_m, "m2_dly");
    endtask

    // one CPU cycle: bus set while M2 low, then hi_len high edges, lo_len low edges
    task automatic bus_cycle(input string tag, input logic rw, input logic rs,
                             input logic a0, input logic a13, input logic a14,
                             input logic [1:0] d, input int hi_len, input int lo_len);
        cpu_rw = rw; romsel_n = rs; cpu_a0 = a0; cpu_a13 = a13; cpu_a14 = a14; cpu_d_hi = d;
        m2 = 1'b1;
        for (int i = 0; i < hi_len; i++) step_and_check(tag);
        m2 = 1'b0;
        for (int i = 0; i < lo_len; i++) step_and_check(tag);
    endtask

    task automatic prot_write(input string tag, input logic [1:0] v, input logic a0);
        bus_cycle(tag, 1'b0, 1'b0, a0, 1'b1, 1'b0, v, 12, 8);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", ram_ce, 1'b0, "ram_ce in reset");
        chk("R1", ram_ce_n, 1'b1, "ram_ce_n in reset");
        chk("R1", ram_we_n, 1'b1, "ram_we_n in reset");
        chk("R1", m2_dly, 1'b0, "m2_dly in reset");
        rst_n = 1'b1;
        repeat (4) step_and_check("R1");

        // R8: protect write enabling reads and writes
        prot_write("R8", 2'b10, 1'b1);
        bus_cycle("R2", 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 2'b00, 12, 8);
        chk("R2", ram_ce, 1'b0, "ram_ce idle after read");
        bus_cycle("R3", 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 2'b01, 12, 8);
        // R3: write-protected, reads still allowed; strobe still pulses (R5)
        prot_write("R8", 2'b11, 1'b1);
        bus_cycle("R3", 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 2'b10, 12, 8);
        bus_cycle("R2", 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'b10, 12, 8);
        // R8: A0=0 write leaves protect unchanged (still 11)
        prot_write("R8", 2'b10, 1'b0);
        bus_cycle("R8", 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 2'b00, 12, 8);
        // R2: disabled
        prot_write("R8", 2'b01, 1'b1);
        bus_cycle("R2", 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 2'b00, 12, 8);
        // R7: short pulse cancels pending assert
        prot_write("R8", 2'b10, 1'b1);
        bus_cycle("R7", 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 2'b00, 3, 8);
        bus_cycle("R7", 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 2'b00, CE_ON - 1, 8);
        // R9: outside window
        bus_cycle("R9", 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'b00, 12, 8);
        bus_cycle("R9", 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 2'b00, 12, 8);

        // random traffic
        void'($urandom(32'h5eed_1234));
        for (int n = 0; n < 400; n++) begin
            int   kind  = $urandom_range(0, 9);
            int   hl    = ($urandom_range(0, 5) == 0) ? $urandom_range(2, 6) : $urandom_range(7, 14);
            int   ll    = $urandom_range(5, 14);
            logic [1:0] d = 2'($urandom_range(0, 3));
            if (kind < 2)
                bus_cycle("R8", 1'b0, 1'b0, 1'($urandom_range(0, 1)), 1'b1, 1'b0, d, hl, ll);
            else if (kind < 5)
                bus_cycle("R2", 1'b1, 1'b1, 1'($urandom_range(0, 1)), 1'b1, 1'b1, d, hl, ll);
            else if (kind < 8)
                bus_cycle("R3", 1'b0, 1'b1, 1'($urandom_range(0, 1)), 1'b1, 1'b1, d, hl, ll);
            else
                bus_cycle("R9", 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                          1'($urandom_range(0, 1)), 1'b0, 1'($urandom_range(0, 1)), d, hl, ll);
        end
        finish_run();
    end
endmodule